// File: doc/BRIEF.md
# UART Receiver with Per-Word Status Queue

This block turns an asynchronous serial line into a queue of received bytes. It samples the line at sixteen times the bit rate. It qualifies a falling edge as a start bit and takes each data bit at the middle of its period. It also checks an optional parity bit and the first stop bit. Each finished byte is written, together with its own parity and framing error flags, into a first-in first-out store. The host drains this store one entry per read strobe.

The error flags travel with their byte. A host that pops an entry therefore sees, on the line-status output, the flags of exactly that byte and of no other. A sticky overrun flag records that a byte was lost because the store was full. A fill level and an empty flag let the host decide when to read. The oversampling strobe comes from an external rate divider. An inversion control lets the block work on a line whose idle level is low.

Top module: `uart_rx_stfifo`

## Requirements
- R1: After reset `empty` is 1, and `fill_lvl`, `ovr_flag`, `rd_data` and `ln_status` are 0.
- R2: With inversion off, the line idles high. A low seen on an oversampling strobe starts a candidate frame, which is kept only if the line is still low 8 strobes later. Otherwise the receiver returns to idle and stores nothing.
- R3: After an accepted start, 8 data bits are taken least significant bit first, each 16 strobes after the previous sample. This places each sample near the middle of its bit.
- R4: With `par_en` high, a parity bit follows the data. `ln_status[0]` of that byte is 1 when the total count of ones in data plus parity is odd while `par_odd`=0, or even while `par_odd`=1. With `par_en` low there is no parity bit and `ln_status[0]` is 0.
- R5: `ln_status[1]` of a byte is 1 when its first stop bit is sampled low.
- R6: Bytes are read oldest first. One cycle after a sampled `rd_stb`, `rd_data` and `ln_status` hold the popped entry.
- R7: The flags shown with a popped byte are the flags recorded for that byte, independent of its neighbours.
- R8: `fill_lvl` gives the number of stored entries, and `empty` is 1 exactly when that number is 0.
- R9: A byte that completes while `fill_lvl` equals DEPTH is discarded, and `ovr_flag` is set. The flag stays set until an `ovr_clr` pulse in a cycle with no new discard.
- R10: `rd_stb` while `empty` is 1 leaves `rd_data`, `ln_status` and `fill_lvl` unchanged.
- R11: With `inv_en` high, the serial input is complemented before decoding, so a line idling low carries the same frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit period |
| rx_in | input | 1 | Asynchronous serial input |
| inv_en | input | 1 | Complement the serial input |
| par_en | input | 1 | Frame carries a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_stb | input | 1 | Pop the oldest entry |
| ovr_clr | input | 1 | Clear the sticky overrun flag |
| rd_data | output | DATA_W | Data of the last popped entry |
| ln_status | output | 2 | Flags of the last popped entry: bit 1 framing, bit 0 parity |
| fill_lvl | output | clog2(DEPTH+1) | Number of stored entries |
| empty | output | 1 | Store holds no entry |
| ovr_flag | output | 1 | Sticky overrun indication |

## Verification
The bench keeps DATA_W at 8 and OSR at 16, and shrinks DEPTH to 8. With that depth, filling the store, the discard of a ninth byte, the sticky overrun flag and the full drain in order all fit in a few thousand cycles. The oversampling strobe fires every second clock, so the receiver also runs on cycles with no strobe. A two-stage input synchroniser adds latency that the mid-bit sampling has to absorb.

// File: rtl/urx_pkg.sv
package urx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } urx_state_e;

  typedef struct packed {
    logic frame_err;
    logic par_err;
  } urx_flags_t;

  localparam int FLAG_W = $bits(urx_flags_t);

endpackage

// File: rtl/urx_linesync.sv
module urx_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  input  logic inv_en,
  output logic line
);

  logic [STAGES-1:0] stg;

  // Polarity is applied before the first flop so that both inputs cross together.
  always_ff @(posedge clk) begin
    if (rst) stg <= '1;
    else     stg <= {stg[STAGES-2:0], rx_in ^ inv_en};
  end

  assign line = stg[STAGES-1];

endmodule

// File: rtl/urx_deframer.sv
module urx_deframer
  import urx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              wr_vld,
  output logic [DATA_W-1:0] wr_data,
  output urx_flags_t        wr_flags
);

  localparam int CW   = $clog2(OSR);
  localparam int BW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HALF = OSR / 2;

  urx_state_e        st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     idx;
  logic [DATA_W-1:0] sh;
  logic              par_bit;
  logic              par_seen;
  logic              par_odd_q;
  logic              bit_end;

  assign bit_end = (cnt == CW'(OSR - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      idx       <= '0;
      sh        <= '0;
      par_bit   <= 1'b0;
      par_seen  <= 1'b0;
      par_odd_q <= 1'b0;
      wr_vld    <= 1'b0;
      wr_data   <= '0;
      wr_flags  <= '0;
    end else begin
      wr_vld <= 1'b0;
      if (tick) begin
        case (st)
          ST_IDLE: begin
            if (!line) begin
              st  <= ST_START;
              cnt <= '0;
            end
          end
          ST_START: begin
            if (cnt == CW'(HALF - 1)) begin
              cnt      <= '0;
              par_seen <= 1'b0;
              if (!line) begin
                st  <= ST_DATA;
                idx <= '0;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (bit_end) begin
              cnt <= '0;
              sh  <= {line, sh[DATA_W-1:1]};
              if (idx == BW'(DATA_W - 1)) begin
                if (par_en) begin
                  st        <= ST_PAR;
                  par_seen  <= 1'b1;
                  par_odd_q <= par_odd;
                end else begin
                  st <= ST_STOP;
                end
              end else begin
                idx <= idx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (bit_end) begin
              cnt     <= '0;
              par_bit <= line;
              st      <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (bit_end) begin
              cnt                <= '0;
              wr_vld             <= 1'b1;
              wr_data            <= sh;
              wr_flags.frame_err <= !line;
              wr_flags.par_err   <= par_seen && (par_bit != ((^sh) ^ par_odd_q));
              st                 <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 128,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic [LVL_W-1:0] level,
  output logic             is_empty,
  output logic             drop
);

  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic             full;
  logic             do_push;
  logic             do_pop;

  assign full    = (level == LVL_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !is_empty;
  assign drop    = push && full;

  // Plain write port without reset, so that block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    if (rst)         pop_data <= '0;
    else if (do_pop) pop_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      is_empty <= 1'b1;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10: begin
          level    <= level + 1'b1;
          is_empty <= 1'b0;
        end
        2'b01: begin
          level    <= level - 1'b1;
          is_empty <= (level == LVL_W'(1));
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_stfifo.sv
module uart_rx_stfifo
  import urx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int DEPTH       = 128,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx_in,
  input  logic              inv_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_stb,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        ln_status,
  output logic [LVL_W-1:0]  fill_lvl,
  output logic              empty,
  output logic              ovr_flag
);

  localparam int ENT_W = DATA_W + FLAG_W;

  logic              line;
  logic              wr_vld;
  logic [DATA_W-1:0] wr_data;
  urx_flags_t        wr_flags;
  logic [ENT_W-1:0]  pop_ent;
  logic              drop;

  urx_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .rx_in  (rx_in),
    .inv_en (inv_en),
    .line   (line)
  );

  urx_deframer #(.DATA_W(DATA_W), .OSR(OSR)) u_defr (
    .clk      (clk),
    .rst      (rst),
    .tick     (os_tick),
    .line     (line),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .wr_vld   (wr_vld),
    .wr_data  (wr_data),
    .wr_flags (wr_flags)
  );

  urx_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_vld),
    .push_data ({wr_flags, wr_data}),
    .pop       (rd_stb),
    .pop_data  (pop_ent),
    .level     (fill_lvl),
    .is_empty  (empty),
    .drop      (drop)
  );

  assign rd_data   = pop_ent[DATA_W-1:0];
  assign ln_status = pop_ent[ENT_W-1:DATA_W];

  // A new loss outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)          ovr_flag <= 1'b0;
    else if (drop)    ovr_flag <= 1'b1;
    else if (ovr_clr) ovr_flag <= 1'b0;
  end

endmodule

// File: rtl/urx_chk.sv
module urx_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int LVL_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_stb,
  input logic              ovr_clr,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        ln_status,
  input logic [LVL_W-1:0]  fill_lvl,
  input logic              empty,
  input logic              ovr_flag
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (fill_lvl == '0 && empty && !ovr_flag && rd_data == '0 && ln_status == '0)); // R1

  AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (rst)
    empty == (fill_lvl == '0)); // R8

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fill_lvl == $past(fill_lvl) || fill_lvl == LVL_W'($past(fill_lvl) + 1'b1)
              || LVL_W'(fill_lvl + 1'b1) == $past(fill_lvl))); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fill_lvl <= LVL_W'(DEPTH)); // R9

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !ovr_clr) |=> ovr_flag); // R9

  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && empty) |=> ($stable(rd_data) && $stable(ln_status))); // R10

endmodule

bind uart_rx_stfifo urx_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_stb    (rd_stb),
  .ovr_clr   (ovr_clr),
  .rd_data   (rd_data),
  .ln_status (ln_status),
  .fill_lvl  (fill_lvl),
  .empty     (empty),
  .ovr_flag  (ovr_flag)
);

// File: tb/test_uart_rx_stfifo.sv
`timescale 1ns/1ps
module test_uart_rx_stfifo;

  localparam int DATA_W = 8;
  localparam int OSR    = 16;
  localparam int DEPTH  = 8;
  localparam int LVL_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              os_tick = 1'b0;
  logic              rx_in = 1'b1;
  logic              inv_en = 1'b0;
  logic              par_en = 1'b0;
  logic              par_odd = 1'b0;
  logic              rd_stb = 1'b0;
  logic              ovr_clr = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic [1:0]        ln_status;
  logic [LVL_W-1:0]  fill_lvl;
  logic              empty;
  logic              ovr_flag;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) os_tick <= ~os_tick;

  uart_rx_stfifo #(.DATA_W(DATA_W), .OSR(OSR), .DEPTH(DEPTH)) i_uart_rx_stfifo (
    .clk       (clk),
    .rst       (rst),
    .os_tick   (os_tick),
    .rx_in     (rx_in),
    .inv_en    (inv_en),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .rd_stb    (rd_stb),
    .ovr_clr   (ovr_clr),
    .rd_data   (rd_data),
    .ln_status (ln_status),
    .fill_lvl  (fill_lvl),
    .empty     (empty),
    .ovr_flag  (ovr_flag)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Logical level v, driven with the bench's current polarity.
  task automatic hold(input logic v, input int ticks);
    rx_in = v ^ inv_en;
    repeat (ticks) @(posedge clk iff os_tick);
    #1;
  endtask

  // pmode: 0 = no parity bit, 1 = correct parity, 2 = wrong parity.
  task automatic send(input logic [7:0] d, input int pmode, input bit stop_ok);
    logic pb;
    hold(1'b0, OSR);
    for (int i = 0; i < 8; i++) hold(d[i], OSR);
    if (pmode != 0) begin
      pb = (^d) ^ par_odd;
      if (pmode == 2) pb = ~pb;
      hold(pb, OSR);
    end
    if (stop_ok) hold(1'b1, OSR);
    else begin
      hold(1'b0, 10);
      hold(1'b1, 22);
    end
    hold(1'b1, OSR);
  endtask

  task automatic pop(input string req, input logic [7:0] exp_d, input logic [1:0] exp_s);
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
    chk(req, "rd_data", 32'(rd_data), 32'(exp_d));
    chk(req, "ln_status", 32'(ln_status), 32'(exp_s));
  endtask

  task automatic t_reset;
    chk("R1", "empty", 32'(empty), 32'd1);
    chk("R1", "fill_lvl", 32'(fill_lvl), 32'd0);
    chk("R1", "ovr_flag", 32'(ovr_flag), 32'd0);
    chk("R1", "rd_data", 32'(rd_data), 32'd0);
    chk("R1", "ln_status", 32'(ln_status), 32'd0);
  endtask

  task automatic t_basic;
    par_en = 1'b0;
    send(8'hA5, 0, 1'b1);
    send(8'h3C, 0, 1'b1);
    send(8'h01, 0, 1'b1);
    @(negedge clk);
    chk("R8", "fill after 3", 32'(fill_lvl), 32'd3);
    chk("R8", "empty after 3", 32'(empty), 32'd0);
    pop("R3 R6 first", 8'hA5, 2'b00);
    pop("R3 R6 second", 8'h3C, 2'b00);
    pop("R3 R6 third", 8'h01, 2'b00);
    chk("R8", "empty after drain", 32'(empty), 32'd1);
  endtask

  task automatic t_glitch;
    hold(1'b0, 4);
    hold(1'b1, 40);
    hold(1'b0, 6);
    hold(1'b1, 40);
    @(negedge clk);
    chk("R2", "fill after glitches", 32'(fill_lvl), 32'd0);
    chk("R2", "empty after glitches", 32'(empty), 32'd1);
  endtask

  task automatic t_parity;
    par_en = 1'b1;
    par_odd = 1'b0;
    send(8'h5A, 1, 1'b1);
    send(8'h5A, 2, 1'b1);
    par_odd = 1'b1;
    send(8'h07, 1, 1'b1);
    send(8'h07, 2, 1'b1);
    pop("R4 R7 even good", 8'h5A, 2'b00);
    pop("R4 R7 even bad", 8'h5A, 2'b01);
    pop("R4 R7 odd good", 8'h07, 2'b00);
    pop("R4 R7 odd bad", 8'h07, 2'b01);
    par_en = 1'b0;
    par_odd = 1'b0;
  endtask

  task automatic t_frame;
    send(8'h81, 0, 1'b0);
    send(8'h42, 0, 1'b1);
    pop("R5 R7 bad stop", 8'h81, 2'b10);
    pop("R5 R7 good stop", 8'h42, 2'b00);
  endtask

  task automatic t_empty_pop;
    pop("R10 pop on empty", 8'h42, 2'b00);
    chk("R10", "fill after empty pop", 32'(fill_lvl), 32'd0);
    chk("R10", "empty after empty pop", 32'(empty), 32'd1);
  endtask

  task automatic t_overrun;
    for (int i = 0; i <= DEPTH; i++) send(8'(8'h10 + i), 0, 1'b1);
    @(negedge clk);
    chk("R9", "fill at full", 32'(fill_lvl), 32'(DEPTH));
    chk("R9", "ovr set", 32'(ovr_flag), 32'd1);
    pop("R9 R6 oldest kept", 8'h10, 2'b00);
    chk("R9", "ovr held after pop", 32'(ovr_flag), 32'd1);
    @(negedge clk) ovr_clr = 1'b1;
    @(negedge clk) ovr_clr = 1'b0;
    chk("R9", "ovr cleared", 32'(ovr_flag), 32'd0);
    for (int i = 1; i < DEPTH; i++) pop("R9 R6 drain order", 8'(8'h10 + i), 2'b00);
    chk("R9", "lost byte absent", 32'(empty), 32'd1);
  endtask

  task automatic t_invert;
    inv_en = 1'b1;
    rx_in = 1'b0;
    hold(1'b1, 40);
    send(8'hC3, 0, 1'b1);
    send(8'h96, 0, 1'b0);
    pop("R11 inverted line", 8'hC3, 2'b00);
    pop("R11 R5 inverted bad stop", 8'h96, 2'b10);
    inv_en = 1'b0;
    rx_in = 1'b1;
    hold(1'b1, 40);
    chk("R11", "no stray frame", 32'(fill_lvl), 32'd0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_glitch();
    t_parity();
    t_frame();
    t_empty_pop();
    t_overrun();
    t_invert();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule